// File: doc/BRIEF.md
# Branch Trace Ring Buffer

The block keeps a short history of retired branches for performance analysis. Each retired branch that passes a programmable filter is written as two consecutive words into an eight-word circular store. The first word holds the branch source and the second holds its target. When the store is full, the oldest pair is overwritten. A write pointer and a sticky wrap flag let software rebuild the oldest-first order after capture. A one-cycle pulse marks every recorded branch, so an external counter can tally them.

The filter can keep or drop a branch based on its taken direction, on whether its target was predicted correctly, and on whether its path was predicted correctly. A separate mode keeps only branches that were mispredicted in some way. A freeze input stops all writes, so the contents stay stable while they are read through the indexed read port.

Top module: `brtrace_ring`

## Requirements
- R1: After a synchronous active-low reset, `wr_ptr` is 0, `wrapped` is 0, `rec_pulse` is 0, and every entry reads with `rd_valid` = 0.
- R2: A recorded branch is written as follows. The source word goes to entry `wr_ptr` and the target word goes to entry `wr_ptr+1`, both on the clock edge that samples `br_valid`. On that same edge `wr_ptr` advances by 2 modulo 8.
- R3: Entry layout. Bit 0 is 1 for a source word and 0 for a target word. Bit 1 is 1 when the branch mispredicted its target or its path. Bits 3:2 hold the slot for a source word and are 0 for a target word. Bits 35:4 hold the 32-bit source bundle address or the target address.
- R4: A fifth recorded branch after reset overwrites entries 0 and 1. All other entries keep their contents.
- R5: `wrapped` becomes 1 on the edge where `wr_ptr` returns from 6 to 0. It then stays 1 until reset.
- R6: `flt_cfg` bit 0 allows taken branches and bit 1 allows not-taken branches. A branch whose direction is not allowed is not recorded.
- R7: `flt_cfg` bit 2 allows branches with a correctly predicted target and bit 3 allows branches with a mispredicted target.
- R8: `flt_cfg` bit 4 allows branches with a correctly predicted path and bit 5 allows branches with a mispredicted path.
- R9: When `flt_cfg` bit 6 is set, only branches with a mispredicted target or path are recorded. This applies in addition to bits 0 to 5.
- R10: `rec_pulse` is high for exactly the one cycle after each recorded branch, once per entry pair. It stays low for filtered branches and for idle cycles.
- R11: While `freeze` is 1, no entry, `wr_ptr`, `wrapped` or `rec_pulse` changes, whatever arrives on the branch inputs.
- R12: `rd_entry` and `rd_valid` show the entry selected by `rd_idx` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A retired branch is presented this cycle |
| br_src_addr | input | 32 | Bundle address of the branch instruction |
| br_slot | input | 2 | Slot of the branch within its bundle |
| br_tgt_addr | input | 32 | Target address |
| br_taken | input | 1 | Branch was taken |
| br_tgt_ok | input | 1 | Target was predicted correctly |
| br_path_ok | input | 1 | Path was predicted correctly |
| flt_cfg | input | 7 | Filter selection (bits per R6 to R9) |
| freeze | input | 1 | Blocks all writes |
| rd_idx | input | 3 | Entry to read |
| rd_entry | output | 36 | Selected entry word |
| rd_valid | output | 1 | Selected entry has been written since reset |
| wr_ptr | output | 3 | Next entry to be written |
| wrapped | output | 1 | Pointer has wrapped at least once |
| rec_pulse | output | 1 | One-cycle pulse per recorded branch |

## Verification
The assertions assume three things about the inputs. `flt_cfg` and `freeze` are taken as sampled on the same edge as the branch they qualify. `br_valid` is only one cycle per branch. Reset is held for at least two edges. The stimulus meets these by changing every input on the falling edge. It presents each branch for a single cycle with a fixed filter setting and holds reset low for several cycles before the first branch.

// File: rtl/brtrace_pkg.sv
// Package: shared filter bit positions and mispredict helper for the
// branch trace ring. Assumes a 7-bit filter configuration word.
package brtrace_pkg;
    localparam int FLT_W        = 7;
    localparam int F_TAKEN      = 0;
    localparam int F_NTAKEN     = 1;
    localparam int F_TGT_OK     = 2;
    localparam int F_TGT_BAD    = 3;
    localparam int F_PATH_OK    = 4;
    localparam int F_PATH_BAD   = 5;
    localparam int F_MISS_ONLY  = 6;

    // Branch counts as mispredicted when target or path was wrong.
    function automatic logic is_miss(input logic tgt_ok, input logic path_ok);
        return ~(tgt_ok & path_ok);
    endfunction
endpackage

// File: rtl/brtrace_filter.sv
// Module: brtrace_filter
// Decides whether a presented branch qualifies for recording, from its
// direction and prediction outcomes and the filter configuration.
// Assumes inputs are stable around the sampling edge; purely combinational.
module brtrace_filter
    import brtrace_pkg::*;
(
    input  logic             taken,
    input  logic             tgt_ok,
    input  logic             path_ok,
    input  logic [FLT_W-1:0] cfg,
    output logic             pass
);
    logic dir_ok;
    logic tgt_allow;
    logic path_allow;
    logic miss_allow;

    // Combine the four independent qualification terms.
    always_comb begin
        dir_ok     = taken   ? cfg[F_TAKEN]   : cfg[F_NTAKEN];
        tgt_allow  = tgt_ok  ? cfg[F_TGT_OK]  : cfg[F_TGT_BAD];
        path_allow = path_ok ? cfg[F_PATH_OK] : cfg[F_PATH_BAD];
        miss_allow = ~cfg[F_MISS_ONLY] | is_miss(tgt_ok, path_ok);
        pass       = dir_ok & tgt_allow & path_allow & miss_allow;
    end
endmodule

// File: rtl/brtrace_ptr.sv
// Module: brtrace_ptr
// Holds the even write pointer, the sticky wrap flag and the registered
// record pulse. Assumes DEPTH is a power of two so the add wraps naturally.
module brtrace_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    output logic [IDX_W-1:0] ptr,
    output logic             wrapped,
    output logic             pulse
);
    localparam logic [IDX_W-1:0] STEP = IDX_W'(2);
    logic [IDX_W-1:0] ptr_nxt;

    // Next position, two entries further around the ring.
    always_comb ptr_nxt = ptr + STEP;

    // Advance pointer, set wrap on return to zero, emit one pulse per pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            wrapped <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= wr_go;
            if (wr_go) begin
                ptr <= ptr_nxt;
                if (ptr_nxt == '0) wrapped <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/brtrace_store.sv
// Module: brtrace_store
// Entry storage: DEPTH words with valid bits, written as a pair at ptr and
// ptr+1, read combinationally by index. Assumes ptr is always even.
module brtrace_store #(
    parameter int DEPTH   = 8,
    parameter int IDX_W   = 3,
    parameter int ENTRY_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_go,
    input  logic [IDX_W-1:0]   ptr,
    input  logic [ENTRY_W-1:0] src_word,
    input  logic [ENTRY_W-1:0] tgt_word,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic               rd_valid
);
    logic [ENTRY_W-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0]   ent_v;
    logic [IDX_W-1:0]   ptr_hi;

    // Partner slot for the target word.
    always_comb ptr_hi = ptr | IDX_W'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [ENTRY_W-1:0] q;
        logic               v;

        // Capture the source or target word when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
                v <= 1'b0;
            end else if (wr_go && (MY_IDX == ptr)) begin
                q <= src_word;
                v <= 1'b1;
            end else if (wr_go && (MY_IDX == ptr_hi)) begin
                q <= tgt_word;
                v <= 1'b1;
            end
        end

        assign ent_q[i] = q;
        assign ent_v[i] = v;
    end

    // Indexed read of the selected entry.
    always_comb begin
        rd_entry = ent_q[rd_idx];
        rd_valid = ent_v[rd_idx];
    end
endmodule

// File: rtl/brtrace_ring.sv
// Module: brtrace_ring (top)
// Records qualified retired branches as source/target word pairs in a
// ring of 2*N_BR entries, with pointer, wrap flag and record pulse.
// Assumes N_BR is a power of two and one branch per cycle at most.
module brtrace_ring
    import brtrace_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int N_BR    = 4,
    parameter int DEPTH   = 2 * N_BR,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int ENTRY_W = ADDR_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_valid,
    input  logic [ADDR_W-1:0]  br_src_addr,
    input  logic [1:0]         br_slot,
    input  logic [ADDR_W-1:0]  br_tgt_addr,
    input  logic               br_taken,
    input  logic               br_tgt_ok,
    input  logic               br_path_ok,
    input  logic [FLT_W-1:0]   flt_cfg,
    input  logic               freeze,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic               rd_valid,
    output logic [IDX_W-1:0]   wr_ptr,
    output logic               wrapped,
    output logic               rec_pulse
);
    logic               pass;
    logic               wr_go;
    logic               miss;
    logic [ENTRY_W-1:0] src_word;
    logic [ENTRY_W-1:0] tgt_word;

    brtrace_filter u_filter (
        .taken   (br_taken),
        .tgt_ok  (br_tgt_ok),
        .path_ok (br_path_ok),
        .cfg     (flt_cfg),
        .pass    (pass)
    );

    // Qualify the write and assemble both entry words.
    always_comb begin
        wr_go    = br_valid & pass & ~freeze;
        miss     = is_miss(br_tgt_ok, br_path_ok);
        src_word = {br_src_addr, br_slot, miss, 1'b1};
        tgt_word = {br_tgt_addr, 2'b00,   miss, 1'b0};
    end

    brtrace_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .ptr     (wr_ptr),
        .wrapped (wrapped),
        .pulse   (rec_pulse)
    );

    brtrace_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .ptr      (wr_ptr),
        .src_word (src_word),
        .tgt_word (tgt_word),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/brtrace_ring_chk.sv
// Module: brtrace_ring_chk
// Property checker bound to brtrace_ring. Observes ports only.
// Assumes reset is held for at least two edges.
module brtrace_ring_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic             br_taken,
    input logic             br_tgt_ok,
    input logic             br_path_ok,
    input logic [6:0]       flt_cfg,
    input logic             freeze,
    input logic [IDX_W-1:0] wr_ptr,
    input logic             wrapped,
    input logic             rec_pulse
);
    // R2: pointer always sits on a pair boundary and steps by two per record.
    p_ptr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[0] == 1'b0);
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_pulse |-> wr_ptr == IDX_W'($past(wr_ptr) + IDX_W'(2)));
    // R10: no pulse, no pointer movement.
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_pulse |-> $stable(wr_ptr));
    // R5: wrap flag is sticky and set when the pointer lands on zero.
    p_wrap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);
    p_wrap_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_pulse && wr_ptr == '0) |-> wrapped);
    // R11: frozen cycle records nothing.
    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !rec_pulse);
    // R9: miss-only mode drops a fully correct branch.
    p_miss_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && flt_cfg[6] && br_tgt_ok && br_path_ok) |=> !rec_pulse);
    // R6: disallowed not-taken branch is dropped.
    p_ntaken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !flt_cfg[1] && !br_taken) |=> !rec_pulse);
endmodule

bind brtrace_ring brtrace_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .br_tgt_ok  (br_tgt_ok),
    .br_path_ok (br_path_ok),
    .flt_cfg    (flt_cfg),
    .freeze     (freeze),
    .wr_ptr     (wr_ptr),
    .wrapped    (wrapped),
    .rec_pulse  (rec_pulse)
);

// File: tb/brtrace_ring_tb.sv
`timescale 1ns/100ps
// Directed bench for brtrace_ring: one task per scenario, a reference
// model of the ring built from the requirements, port-level checks only.
module brtrace_ring_tb;
    localparam int AW = 32;
    localparam int EW = AW + 4;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          br_valid;
    logic [AW-1:0] br_src_addr;
    logic [1:0]    br_slot;
    logic [AW-1:0] br_tgt_addr;
    logic          br_taken;
    logic          br_tgt_ok;
    logic          br_path_ok;
    logic [6:0]    flt_cfg;
    logic          freeze;
    logic [2:0]    rd_idx;
    logic [EW-1:0] rd_entry;
    logic          rd_valid;
    logic [2:0]    wr_ptr;
    logic          wrapped;
    logic          rec_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    logic [EW-1:0] m_ent [D];
    logic [D-1:0]  m_vld;
    logic [2:0]    m_ptr;
    logic          m_wrap;

    always #2 clk = ~clk;

    brtrace_ring u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src_addr(br_src_addr),
        .br_slot(br_slot), .br_tgt_addr(br_tgt_addr), .br_taken(br_taken),
        .br_tgt_ok(br_tgt_ok), .br_path_ok(br_path_ok), .flt_cfg(flt_cfg),
        .freeze(freeze), .rd_idx(rd_idx), .rd_entry(rd_entry), .rd_valid(rd_valid),
        .wr_ptr(wr_ptr), .wrapped(wrapped), .rec_pulse(rec_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare every entry with the model, one read per falling edge (R12).
    task automatic check_all(input string req);
        for (int i = 0; i < D; i++) begin
            rd_idx = 3'(i);
            #0.5;
            check({req, " valid"}, 64'(rd_valid), 64'(m_vld[i]));
            if (m_vld[i]) check({req, " entry"}, 64'(rd_entry), 64'(m_ent[i]));
            @(negedge clk);
        end
    endtask

    // Present one branch; update model per R2 to R11; check pulse and pointer.
    task automatic send(input string req, input logic [AW-1:0] sa, input logic [1:0] sl,
                        input logic [AW-1:0] ta, input logic tk, input logic to,
                        input logic po);
        logic miss, rec;
        miss = ~(to & po);
        rec  = (tk ? flt_cfg[0] : flt_cfg[1]) & (to ? flt_cfg[2] : flt_cfg[3]) &
               (po ? flt_cfg[4] : flt_cfg[5]) & (~flt_cfg[6] | miss) & ~freeze;
        br_valid = 1'b1; br_src_addr = sa; br_slot = sl; br_tgt_addr = ta;
        br_taken = tk; br_tgt_ok = to; br_path_ok = po;
        @(negedge clk);
        br_valid = 1'b0;
        if (rec) begin
            m_ent[m_ptr]      = {sa, sl, miss, 1'b1};
            m_ent[m_ptr + 1]  = {ta, 2'b00, miss, 1'b0};
            m_vld[m_ptr]      = 1'b1;
            m_vld[m_ptr + 1]  = 1'b1;
            m_ptr             = m_ptr + 3'd2;
            if (m_ptr == 3'd0) m_wrap = 1'b1;
        end
        check({req, " R10 pulse"}, 64'(rec_pulse), 64'(rec));
        check({req, " R2 ptr"},    64'(wr_ptr),    64'(m_ptr));
        check({req, " R5 wrap"},   64'(wrapped),   64'(m_wrap));
        @(negedge clk);
        check({req, " R10 pulse low"}, 64'(rec_pulse), 64'd0);
        check_all(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; br_valid = 1'b0; br_src_addr = '0; br_slot = '0;
        br_tgt_addr = '0; br_taken = 1'b0; br_tgt_ok = 1'b1; br_path_ok = 1'b1;
        flt_cfg = 7'h3F; freeze = 1'b0; rd_idx = '0;
        m_vld = '0; m_ptr = '0; m_wrap = 1'b0;
        for (int i = 0; i < D; i++) m_ent[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ptr", 64'(wr_ptr), 64'd0);
        check("R1 wrap", 64'(wrapped), 64'd0);
        check("R1 pulse", 64'(rec_pulse), 64'd0);
        check_all("R1");
    endtask

    // R2 R3: first pair, then fill to wrap (R5) and overwrite (R4).
    task automatic t_fill_wrap();
        send("R3 first", 32'hA000_1000, 2'd2, 32'hB000_2000, 1'b1, 1'b1, 1'b1);
        send("R2 second", 32'hA000_1010, 2'd1, 32'hB000_2010, 1'b0, 1'b1, 1'b1);
        send("R3 miss", 32'hA000_1020, 2'd0, 32'hB000_2020, 1'b1, 1'b0, 1'b1);
        send("R5 wrap", 32'hA000_1030, 2'd3, 32'hB000_2030, 1'b1, 1'b1, 1'b0);
        send("R4 overwrite", 32'hC000_0040, 2'd1, 32'hD000_0040, 1'b1, 1'b1, 1'b1);
    endtask

    // R11: frozen branch leaves everything untouched.
    task automatic t_freeze();
        freeze = 1'b1;
        send("R11 frozen", 32'hEEEE_0000, 2'd3, 32'hFFFF_0000, 1'b1, 1'b0, 1'b0);
        freeze = 1'b0;
    endtask

    // R6 R7 R8: direction and outcome filters.
    task automatic t_filters();
        flt_cfg = 7'h3D;
        send("R6 ntaken dropped", 32'h1111_0000, 2'd0, 32'h2222_0000, 1'b0, 1'b1, 1'b1);
        send("R6 taken kept",     32'h1111_0010, 2'd1, 32'h2222_0010, 1'b1, 1'b1, 1'b1);
        flt_cfg = 7'h3E;
        send("R6 taken dropped",  32'h1111_0020, 2'd1, 32'h2222_0020, 1'b1, 1'b1, 1'b1);
        flt_cfg = 7'h3B;
        send("R7 tgt ok dropped", 32'h3333_0000, 2'd2, 32'h4444_0000, 1'b1, 1'b1, 1'b1);
        send("R7 tgt bad kept",   32'h3333_0010, 2'd2, 32'h4444_0010, 1'b1, 1'b0, 1'b1);
        flt_cfg = 7'h1F;
        send("R8 path bad dropped", 32'h5555_0000, 2'd3, 32'h6666_0000, 1'b0, 1'b1, 1'b0);
        send("R8 path ok kept",     32'h5555_0010, 2'd3, 32'h6666_0010, 1'b0, 1'b1, 1'b1);
        flt_cfg = 7'h2F;
        send("R8 path ok dropped",  32'h5555_0020, 2'd0, 32'h6666_0020, 1'b1, 1'b1, 1'b1);
    endtask

    // R9: miss-only keeps only mispredicted branches.
    task automatic t_miss_only();
        flt_cfg = 7'h7F;
        send("R9 correct dropped", 32'h7777_0000, 2'd1, 32'h8888_0000, 1'b1, 1'b1, 1'b1);
        send("R9 path miss kept",  32'h7777_0010, 2'd1, 32'h8888_0010, 1'b1, 1'b1, 1'b0);
        send("R9 tgt miss kept",   32'h7777_0020, 2'd2, 32'h8888_0020, 1'b0, 1'b0, 1'b1);
        flt_cfg = 7'h3F;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_wrap();
        t_freeze();
        t_filters();
        t_miss_only();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule